// File: doc/BRIEF.md
# PFC-to-LLC Power Sequencing Controller

This block orders the start-up and shutdown of a power-factor-correction (PFC) front end and the resonant (LLC) converter stage that follows it. External comparators supply digital flags: a remote-on request, a PFC-ready flag, a flag for bulk voltage below the power-good threshold, and a flag for bulk voltage below the brownout (LLC stop) threshold. The block drives three outputs: a PFC enable, an LLC driver enable and an active-low power-good indication.

Each input flag passes through a two-flop synchronizer. A five-state machine then reacts to the flags. A start timer keeps the LLC off until the PFC has been ready for a set time. A stop timer keeps the LLC drivers running for a set time after power-good has been dropped, so that downstream loads get warning before the output collapses. Both delays are parameters in milliseconds. They are converted to clock ticks from a clock-frequency parameter. The defaults are a 20 ms start delay and a 5 ms stop delay.

Latency: for every input the synchronizer adds two clock edges and the state register adds one. An immediate reaction therefore appears on the third rising edge after the input changes.

Top module: `pwrseq_ctrl`

## Requirements
- R1: When synchronous reset is active and after it is released, `pfc_en_o`=0, `llc_en_o`=0 and `pg_n_o`=1 until an input request arrives.
- R2: When `remote_on_i` rises, `pfc_en_o` rises on the third clock edge after the change. `llc_en_o` stays 0.
- R3: Consider `pfc_ok_i` rising while the PFC is enabled and no brownout is flagged. Then `llc_en_o` rises and `pg_n_o` falls together, exactly START_TICKS+3 edges after the change.
- R4: If `pfc_ok_i` falls before the start delay expires, the delay is cancelled: `llc_en_o` stays 0 and `pg_n_o` stays 1. A later rise of `pfc_ok_i` starts a full new START_TICKS count.
- R5: Consider `bulk_lo_pg_i` going high while running. Then `pg_n_o` returns to 1 three edges later. `llc_en_o` stays 1 for STOP_TICKS further edges and then falls.
- R6: Consider `pfc_ok_i` falling while running (brownout). Then `pg_n_o` returns to 1 three edges later, and `llc_en_o` falls STOP_TICKS edges after that.
- R7: Consider `bulk_lo_bo_i` going high while the LLC runs. Then `llc_en_o` falls three edges later, without a stop delay. While the flag is high the LLC cannot start.
- R8: When `remote_on_i` falls, all three outputs go to their inactive values (0, 0, 1) three edges later, from any state.
- R9: `pg_n_o` is 0 only while `llc_en_o` is 1. `llc_en_o` is 1 only while `pfc_en_o` is 1.
- R10: After a stop completes with `remote_on_i` still 1, `pfc_en_o` stays 1. If `pfc_ok_i` is 1, a new start delay begins on the next edge, and the LLC restarts START_TICKS edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remote_on_i | input | 1 | Remote request, 1 = run, 0 = low-power off |
| pfc_ok_i | input | 1 | PFC stage reports bulk voltage in range |
| bulk_lo_pg_i | input | 1 | Bulk voltage below the power-good level |
| bulk_lo_bo_i | input | 1 | Bulk voltage below the LLC stop (brownout) level |
| pfc_en_o | output | 1 | PFC enable |
| llc_en_o | output | 1 | LLC driver enable |
| pg_n_o | output | 1 | Power-good, active low |

## Verification
The assertions watch the synchronized copies of the flags. They assume that each flag holds steady long enough to pass the two-flop stage, so that the copies reflect a clean level and never a glitch. The stimulus changes each input only on a falling clock edge and then holds it for several cycles. Every scenario also leaves the flags static for longer than a full start or stop delay before it checks the settled outputs.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_START = 3'd2,
    ST_RUN   = 3'd3,
    ST_STOP  = 3'd4
  } seq_state_t;

  function automatic int unsigned ms_to_ticks(input int unsigned clk_hz,
                                              input int unsigned ms);
    int unsigned t;
    t = (clk_hz / 1000) * ms;
    return (t < 2) ? 2 : t;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d_i[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int unsigned LIMIT = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  output logic done_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = active_i && (cnt_q == LAST);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       on_i,
  input  logic       ok_i,
  input  logic       pgl_i,
  input  logic       bol_i,
  input  logic       start_done_i,
  input  logic       stop_done_i,
  output seq_state_t st_o,
  output logic       pfc_en_o,
  output logic       llc_en_o,
  output logic       pg_n_o
);

  seq_state_t st_q, st_nxt;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_OFF:   if (on_i) st_nxt = ST_WAIT;
      ST_WAIT:  if (ok_i && !bol_i) st_nxt = ST_START;
      ST_START: begin
        if (!ok_i || bol_i)     st_nxt = ST_WAIT;
        else if (start_done_i)  st_nxt = ST_RUN;
      end
      ST_RUN: begin
        if (bol_i)              st_nxt = ST_WAIT;
        else if (!ok_i || pgl_i) st_nxt = ST_STOP;
      end
      ST_STOP:  if (bol_i || stop_done_i) st_nxt = ST_WAIT;
      default:  st_nxt = ST_OFF;
    endcase
    if (!on_i) st_nxt = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      pfc_en_o <= 1'b0;
      llc_en_o <= 1'b0;
      pg_n_o   <= 1'b1;
    end else begin
      st_q     <= st_nxt;
      pfc_en_o <= (st_nxt != ST_OFF);
      llc_en_o <= (st_nxt == ST_RUN) || (st_nxt == ST_STOP);
      pg_n_o   <= (st_nxt != ST_RUN);
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned START_MS = 20,
  parameter int unsigned STOP_MS  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic remote_on_i,
  input  logic pfc_ok_i,
  input  logic bulk_lo_pg_i,
  input  logic bulk_lo_bo_i,
  output logic pfc_en_o,
  output logic llc_en_o,
  output logic pg_n_o
);

  localparam int unsigned START_TICKS = ms_to_ticks(CLK_HZ, START_MS);
  localparam int unsigned STOP_TICKS  = ms_to_ticks(CLK_HZ, STOP_MS);
  localparam int NFLAG = 4;

  logic [NFLAG-1:0] flags_raw, flags_s;
  logic on_q, ok_q, pgl_q, bol_q;
  logic start_done, stop_done;
  seq_state_t st;

  assign flags_raw = {bulk_lo_bo_i, bulk_lo_pg_i, pfc_ok_i, remote_on_i};

  pwrseq_sync #(.W(NFLAG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (flags_raw),
    .q_o (flags_s)
  );

  assign on_q  = flags_s[0];
  assign ok_q  = flags_s[1];
  assign pgl_q = flags_s[2];
  assign bol_q = flags_s[3];

  pwrseq_timer #(.LIMIT(START_TICKS)) u_start_tmr (
    .clk      (clk),
    .rst      (rst),
    .active_i (st == ST_START),
    .done_o   (start_done)
  );

  pwrseq_timer #(.LIMIT(STOP_TICKS)) u_stop_tmr (
    .clk      (clk),
    .rst      (rst),
    .active_i (st == ST_STOP),
    .done_o   (stop_done)
  );

  pwrseq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .on_i         (on_q),
    .ok_i         (ok_q),
    .pgl_i        (pgl_q),
    .bol_i        (bol_q),
    .start_done_i (start_done),
    .stop_done_i  (stop_done),
    .st_o         (st),
    .pfc_en_o     (pfc_en_o),
    .llc_en_o     (llc_en_o),
    .pg_n_o       (pg_n_o)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int unsigned STOP_TICKS = 5000
) (
  input logic clk,
  input logic rst,
  input logic on_s,
  input logic ok_s,
  input logic pgl_s,
  input logic bol_s,
  input logic pfc_en,
  input logic llc_en,
  input logic pg_n
);

  localparam int CW = $clog2(STOP_TICKS + 2);
  logic [CW-1:0] drain_cnt;

  always_ff @(posedge clk) begin
    if (rst || !(llc_en && pg_n)) drain_cnt <= '0;
    else if (drain_cnt != {CW{1'b1}}) drain_cnt <= drain_cnt + 1'b1;
  end

  p_llc_needs_pfc_r9: assert property (@(posedge clk) disable iff (rst)
    llc_en |-> pfc_en);

  p_pg_with_llc_r9: assert property (@(posedge clk) disable iff (rst)
    !pg_n |-> llc_en);

  p_start_together_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(llc_en) |-> $fell(pg_n));

  p_remote_off_r8: assert property (@(posedge clk) disable iff (rst)
    !on_s |=> (!pfc_en && !llc_en && pg_n));

  p_bo_stop_r7: assert property (@(posedge clk) disable iff (rst)
    bol_s |=> !llc_en);

  p_cancel_r4: assert property (@(posedge clk) disable iff (rst)
    (!ok_s && !llc_en) |=> !llc_en);

  p_pg_release_r5: assert property (@(posedge clk) disable iff (rst)
    (!pg_n && (pgl_s || !ok_s)) |=> pg_n);

  p_stop_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (llc_en && pg_n) |-> (drain_cnt <= CW'(STOP_TICKS)));

endmodule

bind pwrseq_ctrl pwrseq_chk #(.STOP_TICKS(STOP_TICKS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .on_s   (on_q),
  .ok_s   (ok_q),
  .pgl_s  (pgl_q),
  .bol_s  (bol_q),
  .pfc_en (pfc_en_o),
  .llc_en (llc_en_o),
  .pg_n   (pg_n_o)
);

// File: tb/sim_pwrseq_ctrl.sv
module sim_pwrseq_ctrl;

  localparam time PERIOD = 10ns;
  localparam int unsigned CLK_HZ = 2000;
  localparam int START_T = 40;
  localparam int STOP_T  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic remote_on = 1'b0, pfc_ok = 1'b0, lo_pg = 1'b0, lo_bo = 1'b0;
  logic pfc_en, llc_en, pg_n;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pwrseq_ctrl #(.CLK_HZ(CLK_HZ), .START_MS(20), .STOP_MS(5)) u0 (
    .clk (clk), .rst (rst),
    .remote_on_i (remote_on), .pfc_ok_i (pfc_ok),
    .bulk_lo_pg_i (lo_pg), .bulk_lo_bo_i (lo_bo),
    .pfc_en_o (pfc_en), .llc_en_o (llc_en), .pg_n_o (pg_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(4);
    chk("R1", "pfc_en in reset", pfc_en, 1'b0);
    chk("R1", "llc_en in reset", llc_en, 1'b0);
    chk("R1", "pg_n in reset", pg_n, 1'b1);
    rst = 1'b0;
    tick(5);
    chk("R1", "pfc_en after reset", pfc_en, 1'b0);
    chk("R1", "pg_n after reset", pg_n, 1'b1);
  endtask

  task automatic t_power_on();
    remote_on = 1'b1;
    tick(2);
    chk("R2", "pfc_en before latency", pfc_en, 1'b0);
    tick(1);
    chk("R2", "pfc_en on", pfc_en, 1'b1);
    chk("R2", "llc_en stays off", llc_en, 1'b0);
  endtask

  task automatic t_start();
    pfc_ok = 1'b1;
    tick(2 + START_T);
    chk("R3", "llc_en one edge early", llc_en, 1'b0);
    chk("R3", "pg_n one edge early", pg_n, 1'b1);
    tick(1);
    chk("R3", "llc_en started", llc_en, 1'b1);
    chk("R9", "pg_n asserted with llc", pg_n, 1'b0);
  endtask

  task automatic t_pg_stop();
    lo_pg = 1'b1;
    tick(2);
    chk("R5", "pg_n before latency", pg_n, 1'b0);
    tick(1);
    chk("R5", "pg_n released", pg_n, 1'b1);
    chk("R5", "llc_en still running", llc_en, 1'b1);
    tick(STOP_T - 1);
    chk("R5", "llc_en last stop cycle", llc_en, 1'b1);
    tick(1);
    chk("R5", "llc_en stopped", llc_en, 1'b0);
    lo_pg = 1'b0;
    chk("R10", "pfc_en kept after stop", pfc_en, 1'b1);
    tick(START_T);
    chk("R10", "llc_en before restart", llc_en, 1'b0);
    tick(1);
    chk("R10", "llc_en restarted", llc_en, 1'b1);
    chk("R10", "pg_n restarted", pg_n, 1'b0);
  endtask

  task automatic t_brownout_stop();
    pfc_ok = 1'b0;
    tick(3);
    chk("R6", "pg_n released", pg_n, 1'b1);
    chk("R6", "llc_en still running", llc_en, 1'b1);
    tick(STOP_T - 1);
    chk("R6", "llc_en last stop cycle", llc_en, 1'b1);
    tick(1);
    chk("R6", "llc_en stopped", llc_en, 1'b0);
    chk("R6", "pfc_en kept", pfc_en, 1'b1);
  endtask

  task automatic t_cancel();
    pfc_ok = 1'b1;
    tick(20);
    pfc_ok = 1'b0;
    tick(START_T);
    chk("R4", "llc_en after cancel", llc_en, 1'b0);
    chk("R4", "pg_n after cancel", pg_n, 1'b1);
    pfc_ok = 1'b1;
    tick(2 + START_T);
    chk("R4", "llc_en full recount early", llc_en, 1'b0);
    tick(1);
    chk("R4", "llc_en after full recount", llc_en, 1'b1);
  endtask

  task automatic t_bo_immediate();
    lo_bo = 1'b1;
    tick(2);
    chk("R7", "llc_en before latency", llc_en, 1'b1);
    tick(1);
    chk("R7", "llc_en cut at once", llc_en, 1'b0);
    chk("R7", "pg_n released", pg_n, 1'b1);
    tick(60);
    chk("R7", "no start during brownout", llc_en, 1'b0);
    lo_bo = 1'b0;
    tick(60);
    chk("R7", "start after brownout clears", llc_en, 1'b1);
  endtask

  task automatic t_remote_off();
    remote_on = 1'b0;
    tick(2);
    chk("R8", "llc_en before latency", llc_en, 1'b1);
    tick(1);
    chk("R8", "pfc_en off", pfc_en, 1'b0);
    chk("R8", "llc_en off", llc_en, 1'b0);
    chk("R8", "pg_n released", pg_n, 1'b1);
    remote_on = 1'b1;
    tick(20);
    remote_on = 1'b0;
    tick(3);
    chk("R8", "pfc_en off during start delay", pfc_en, 1'b0);
    tick(START_T);
    chk("R8", "llc_en stays off", llc_en, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_power_on();
    t_start();
    t_pg_stop();
    t_brownout_stop();
    t_cancel();
    t_bo_immediate();
    t_remote_off();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule